// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a first-in first-out buffer of 18-bit words. Its write port and its read port each run on their own clock. The two clocks may be unrelated or may be the very same clock. Depth is a parameter and defaults to 256 words; any power of two from 256 to 4096 works.

Five active-low status outputs report the fill level:
- full and empty;
- a flag that marks more than half full;
- two programmable flags for almost full and almost empty.

The two programmable thresholds sit in a pair of 12-bit offset registers. These are written through the data input while the load control is low. A small selector state machine in the write domain decides which register a load write goes to:
- reset places it in SEL_EMPTY_OFS;
- a load write in SEL_EMPTY_OFS fills the empty offset and moves it to SEL_FULL_OFS;
- a load write in SEL_FULL_OFS fills the full offset and moves it back to SEL_EMPTY_OFS.

Raising the load control keeps the selector where it is. The next load session therefore continues the sequence.

Reads land in a registered output. A word, including the first word after an empty period, appears only after an explicit read request. An output-enable input models the bus drive. When it is disabled, the data is forced to zero and the valid indication drops.

The read pointer is passed into the write domain as Gray code through two-flop synchronisers, and the write pointer is passed into the read domain the same way. This makes every flag conservative.

Top module: `dual_clock_pflag_fifo`

## Requirements
- R1: While rst_n is low, both pointers return to the first location, full_n, half_n and paf_n go high, empty_n and pae_n go low, the output register clears to zero, and both offsets return to DEF_OFS (31 by default).
- R2: On a rising wclk edge with wen_n low, ld_n high and full_n high, din is stored. While full_n is low, a write request is ignored and no stored word is disturbed.
- R3: On a rising rclk edge with ren_n low, ld_n high and empty_n high, the oldest word moves into the output register. With ren_n high, or while empty_n is low, the output register keeps its value.
- R4: A word written into an empty FIFO does not appear at q until a read request moves it into the output register.
- R5: Words leave in the order they were accepted, with unrelated clock periods and with one shared clock.
- R6: Once both clock domains are quiet, full_n is low exactly when DEPTH words are stored and empty_n is low exactly when none are. Full is released after a read and empty after a write, within the synchroniser latency.
- R7: Once settled, half_n is low exactly when more than DEPTH/2 words are stored.
- R8: Once settled, pae_n is low exactly when the stored count is at or below the empty offset, and paf_n is low exactly when the stored count is at or above DEPTH minus the full offset.
- R9: A rising wclk edge with wen_n and ld_n both low writes din[11:0] into the offset chosen by the selector (empty offset first, then full offset, alternating, the position kept across load sessions) and stores no word in the FIFO.
- R10: With oe_n high, q_valid is low and q reads zero. With oe_n low, q_valid is high and q shows the output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| din | input | 18 | Write data; bits 11:0 also carry offset values during a load |
| wen_n | input | 1 | Active-low write request |
| ren_n | input | 1 | Active-low read request |
| ld_n | input | 1 | Active-low offset load control |
| oe_n | input | 1 | Active-low output enable |
| q | output | 18 | Output register contents, zero when disabled |
| q_valid | output | 1 | High while the output is enabled |
| full_n | output | 1 | Low when full (write domain) |
| empty_n | output | 1 | Low when empty (read domain) |
| half_n | output | 1 | Low when more than half full (write domain) |
| paf_n | output | 1 | Low when almost full (write domain) |
| pae_n | output | 1 | Low when almost empty (read domain) |

## Verification
A write and a read can fall in the same cycle at both boundaries:
- a word arrives while the last stored word is being taken out;
- a read frees a slot on the same edge that a write meets a full flag.

The bench provokes both with long streams on both ports. It toggles the requests in unrelated patterns, first with a 26 ns read clock against the 20 ns write clock and then with both ports on one clock, so the FIFO swings through full and empty repeatedly. The scoreboard judges each case in two ways. Every accepted write must come out once and in order, so a word lost, duplicated or overwritten in the race shows up as a data mismatch. Every read granted while the reference queue is empty counts as a failure of the conservative flag.

// File: rtl/pff_pkg.sv
package pff_pkg;

    // Selector for the next offset register written by a load cycle.
    typedef enum logic {
        SEL_EMPTY_OFS = 1'b0,
        SEL_FULL_OFS  = 1'b1
    } ofs_sel_e;

endpackage

// File: rtl/pff_gray_sync.sv
// Two-flop synchroniser for a Gray-coded pointer, followed by decode to binary.
module pff_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    // Gray to binary: each bit is the XOR of all Gray bits at or above it.
    always_comb begin
        bin_out[W-1] = stage2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage2_q[i];
        end
    end
endmodule

// File: rtl/pff_ram.sv
// Storage array: written on the write clock, read asynchronously by address.
module pff_ram #(
    parameter int DW = 18,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [DW-1:0] cells [ENTRIES];

    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pff_wr_side.sv
// Write domain: pointer, full / half / almost-full flags, offset load selector.
module pff_wr_side
    import pff_pkg::*;
#(
    parameter int DW      = 18,
    parameter int AW      = 8,
    parameter int OFS_W   = 12,
    parameter int DEF_OFS = 31
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             wen_n,
    input  logic             ld_n,
    input  logic [DW-1:0]    din,
    input  logic [AW:0]      rbin_sync,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [AW:0]      wbin,
    output logic [AW:0]      wgray,
    output logic             full_n,
    output logic             half_n,
    output logic             paf_n,
    output logic [OFS_W-1:0] empty_ofs,
    output logic [OFS_W-1:0] full_ofs
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = ((PW > OFS_W) ? PW : OFS_W) + 1;

    ofs_sel_e      sel_q;
    ofs_sel_e      sel_d;
    logic          load_empty;
    logic          load_full;
    logic          push;
    logic [PW-1:0] wbin_d;
    logic [PW-1:0] cnt_d;
    logic [CW-1:0] cnt_x;
    logic [CW-1:0] fofs_x;

    assign push      = !wen_n && ld_n && full_n;
    assign ram_we    = push;
    assign ram_waddr = wbin[AW-1:0];

    // Selector state register.
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= SEL_EMPTY_OFS;
        end else begin
            sel_q <= sel_d;
        end
    end

    // Selector transitions and load strobes.
    always_comb begin
        sel_d      = sel_q;
        load_empty = 1'b0;
        load_full  = 1'b0;
        if (!wen_n && !ld_n) begin
            unique case (sel_q)
                SEL_EMPTY_OFS: begin
                    load_empty = 1'b1;
                    sel_d      = SEL_FULL_OFS;
                end
                SEL_FULL_OFS: begin
                    load_full  = 1'b1;
                    sel_d      = SEL_EMPTY_OFS;
                end
            endcase
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            empty_ofs <= OFS_W'(DEF_OFS);
            full_ofs  <= OFS_W'(DEF_OFS);
        end else begin
            if (load_empty) empty_ofs <= din[OFS_W-1:0];
            if (load_full)  full_ofs  <= din[OFS_W-1:0];
        end
    end

    // Level after this edge, measured against the (possibly stale) read pointer.
    assign wbin_d = wbin + PW'(push);
    assign cnt_d  = wbin_d - rbin_sync;
    assign cnt_x  = CW'(cnt_d);
    assign fofs_x = CW'(full_ofs);

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin   <= '0;
            wgray  <= '0;
            full_n <= 1'b1;
            half_n <= 1'b1;
            paf_n  <= 1'b1;
        end else begin
            wbin   <= wbin_d;
            wgray  <= wbin_d ^ (wbin_d >> 1);
            full_n <= !(cnt_x == CW'(DEPTH));
            half_n <= !(cnt_x > CW'(DEPTH / 2));
            paf_n  <= !((cnt_x + fofs_x) >= CW'(DEPTH));
        end
    end
endmodule

// File: rtl/pff_rd_side.sv
// Read domain: pointer, empty / almost-empty flags, registered output.
module pff_rd_side #(
    parameter int DW    = 18,
    parameter int AW    = 8,
    parameter int OFS_W = 12
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             ren_n,
    input  logic             ld_n,
    input  logic [AW:0]      wbin_sync,
    input  logic [OFS_W-1:0] empty_ofs,
    input  logic [DW-1:0]    ram_rdata,
    output logic [AW-1:0]    ram_raddr,
    output logic [AW:0]      rbin,
    output logic [AW:0]      rgray,
    output logic             empty_n,
    output logic             pae_n,
    output logic [DW-1:0]    dout_q
);
    localparam int PW = AW + 1;
    localparam int CW = ((PW > OFS_W) ? PW : OFS_W) + 1;

    logic          pop;
    logic [PW-1:0] rbin_d;
    logic [PW-1:0] cnt_d;

    assign pop       = !ren_n && ld_n && empty_n;
    assign ram_raddr = rbin[AW-1:0];
    assign rbin_d    = rbin + PW'(pop);
    assign cnt_d     = wbin_sync - rbin_d;

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin    <= '0;
            rgray   <= '0;
            empty_n <= 1'b0;
            pae_n   <= 1'b0;
            dout_q  <= '0;
        end else begin
            rbin    <= rbin_d;
            rgray   <= rbin_d ^ (rbin_d >> 1);
            empty_n <= (cnt_d != '0);
            pae_n   <= !(CW'(cnt_d) <= CW'(empty_ofs));
            if (pop) begin
                dout_q <= ram_rdata;
            end
        end
    end
endmodule

// File: rtl/dual_clock_pflag_fifo.sv
module dual_clock_pflag_fifo #(
    parameter int DATA_W  = 18,
    parameter int DEPTH   = 256,
    parameter int OFS_W   = 12,
    parameter int DEF_OFS = 31
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wen_n,
    input  logic              ren_n,
    input  logic              ld_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] q,
    output logic              q_valid,
    output logic              full_n,
    output logic              empty_n,
    output logic              half_n,
    output logic              paf_n,
    output logic              pae_n
);
    localparam int AW = $clog2(DEPTH);

    logic              ram_we;
    logic [AW-1:0]     ram_waddr;
    logic [AW-1:0]     ram_raddr;
    logic [DATA_W-1:0] ram_rdata;
    logic [AW:0]       wbin;
    logic [AW:0]       wgray;
    logic [AW:0]       rbin;
    logic [AW:0]       rgray;
    logic [AW:0]       wbin_sync;
    logic [AW:0]       rbin_sync;
    logic [OFS_W-1:0]  empty_ofs;
    logic [OFS_W-1:0]  full_ofs;
    logic [DATA_W-1:0] dout_q;

    pff_wr_side #(.DW(DATA_W), .AW(AW), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .ld_n(ld_n), .din(din),
        .rbin_sync(rbin_sync), .ram_we(ram_we), .ram_waddr(ram_waddr),
        .wbin(wbin), .wgray(wgray), .full_n(full_n), .half_n(half_n),
        .paf_n(paf_n), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    pff_rd_side #(.DW(DATA_W), .AW(AW), .OFS_W(OFS_W)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .ld_n(ld_n),
        .wbin_sync(wbin_sync), .empty_ofs(empty_ofs), .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr), .rbin(rbin), .rgray(rgray),
        .empty_n(empty_n), .pae_n(pae_n), .dout_q(dout_q)
    );

    pff_ram #(.DW(DATA_W), .AW(AW)) u_ram (
        .wclk(wclk), .we(ram_we), .waddr(ram_waddr), .wdata(din),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    pff_gray_sync #(.W(AW + 1)) u_sync_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_sync)
    );

    pff_gray_sync #(.W(AW + 1)) u_sync_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_sync)
    );

    assign q       = oe_n ? '0 : dout_q;
    assign q_valid = !oe_n;
endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
    parameter int DW    = 18,
    parameter int AW    = 8,
    parameter int DEPTH = 256
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen_n,
    input logic          ren_n,
    input logic          ld_n,
    input logic          full_n,
    input logic          empty_n,
    input logic          half_n,
    input logic          paf_n,
    input logic          pae_n,
    input logic [AW:0]   wptr,
    input logic [AW:0]   rptr,
    input logic [DW-1:0] dout
);
    // R1: flags in their reset state at the first edge after reset release
    a_r1_wr_reset_flags: assert property (@(posedge wclk) disable iff (!rst_n)
        $rose(rst_n) |-> (full_n && half_n && paf_n));
    a_r1_rd_reset_state: assert property (@(posedge rclk) disable iff (!rst_n)
        $rose(rst_n) |-> (!empty_n && !pae_n && dout == '0));

    // R2: a write request while full leaves the write pointer unmoved
    a_r2_no_write_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
        (!full_n && !wen_n) |=> $stable(wptr));

    // R3: a read request while empty leaves the read pointer unmoved
    a_r3_no_read_when_empty: assert property (@(posedge rclk) disable iff (!rst_n)
        (!empty_n && !ren_n) |=> $stable(rptr));

    // R3: without a granted read request the output register holds
    a_r3_hold_output: assert property (@(posedge rclk) disable iff (!rst_n)
        (ren_n || !ld_n) |=> $stable(dout));

    // R6: the stored count never exceeds DEPTH
    a_r6_no_overrun: assert property (@(posedge wclk) disable iff (!rst_n)
        (wptr - rptr) <= (AW + 1)'(DEPTH));

    // R7: full implies half-full and almost-full
    a_r7_full_implies_levels: assert property (@(posedge wclk) disable iff (!rst_n)
        !full_n |-> (!half_n && !paf_n));

    // R8: empty implies almost-empty
    a_r8_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
        !empty_n |-> !pae_n);
endmodule

bind dual_clock_pflag_fifo pff_checker #(.DW(DATA_W), .AW(AW), .DEPTH(DEPTH)) u_pff_checker (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
    .ld_n(ld_n), .full_n(full_n), .empty_n(empty_n), .half_n(half_n),
    .paf_n(paf_n), .pae_n(pae_n), .wptr(wbin), .rptr(rbin), .dout(dout_q)
);

// File: tb/tb_dual_clock_pflag_fifo.sv
module tb_dual_clock_pflag_fifo;
    localparam int DEPTH = 256;
    localparam int DEF   = 31;

    logic        wclk = 1'b0;
    logic        rclk_free = 1'b0;
    logic        same_clk = 1'b0;
    logic        rclk;
    logic        rst_n = 1'b0;
    logic [17:0] din = '0;
    logic        wen_n = 1'b1;
    logic        ren_n = 1'b1;
    logic        ld_n = 1'b1;
    logic        oe_n = 1'b0;
    logic [17:0] q;
    logic        q_valid, full_n, empty_n, half_n, paf_n, pae_n;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [17:0] exp_q[$];
    logic [17:0] exp_word;
    logic [17:0] last_q = '0;
    logic        pend = 1'b0;
    logic [17:0] dat = 18'h00100;

    always #10 wclk = ~wclk;
    always #13 rclk_free = ~rclk_free;
    assign rclk = same_clk ? wclk : rclk_free;

    dual_clock_pflag_fifo dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wen_n(wen_n),
        .ren_n(ren_n), .ld_n(ld_n), .oe_n(oe_n), .q(q), .q_valid(q_valid),
        .full_n(full_n), .empty_n(empty_n), .half_n(half_n), .paf_n(paf_n),
        .pae_n(pae_n)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr_cycle(input logic w, input logic l, input logic [17:0] d);
        @(posedge wclk); #3;
        wen_n = w; ld_n = l; din = d;
    endtask

    task automatic rd_cycle(input logic r);
        @(posedge rclk); #3;
        ren_n = r;
    endtask

    // Write-side monitor: an accepted word is pushed into the reference queue.
    always @(negedge wclk) begin
        if (rst_n && !wen_n && ld_n && full_n) exp_q.push_back(din);
    end

    // Read-side monitor: data order (R5) and output hold (R3).
    always @(negedge rclk) begin
        if (!rst_n) begin
            pend = 1'b0;
            last_q = '0;
        end else if (!oe_n) begin
            if (pend) begin
                chk(q == exp_word, "R5", "read data", int'(q), int'(exp_word));
                last_q = q;
                pend = 1'b0;
            end else begin
                chk(q == last_q, "R3", "output hold", int'(q), int'(last_q));
            end
            if (!ren_n && ld_n && empty_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6", "read granted with nothing stored", 1, 0);
                end else begin
                    exp_word = exp_q.pop_front();
                    pend = 1'b1;
                end
            end
        end
    end

    task automatic settle();
        wr_cycle(1'b1, 1'b1, '0);
        rd_cycle(1'b1);
        repeat (5) @(posedge rclk);
        repeat (5) @(posedge wclk);
        repeat (5) @(posedge rclk);
        @(negedge wclk);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) begin
            wr_cycle(1'b0, 1'b1, dat);
            dat = dat + 18'h00B3;
        end
        wr_cycle(1'b1, 1'b1, '0);
    endtask

    task automatic check_levels(input int eofs, input int fofs, input string tag);
        int c;
        settle();
        c = exp_q.size();
        chk(full_n == !(c == DEPTH), "R6", "full_n", int'(full_n), int'(!(c == DEPTH)));
        chk(empty_n == (c != 0), "R6", "empty_n", int'(empty_n), int'(c != 0));
        chk(half_n == !(c > DEPTH / 2), "R7", "half_n", int'(half_n), int'(!(c > DEPTH / 2)));
        chk(pae_n == !(c <= eofs), tag, "pae_n", int'(pae_n), int'(!(c <= eofs)));
        chk(paf_n == !(c >= DEPTH - fofs), tag, "paf_n", int'(paf_n), int'(!(c >= DEPTH - fofs)));
    endtask

    task automatic drain();
        for (int i = 0; i < DEPTH + 20; i++) rd_cycle(1'b0);
        rd_cycle(1'b1);
        settle();
        chk(exp_q.size() == 0, "R5", "words left after drain", exp_q.size(), 0);
        chk(empty_n == 1'b0, "R6", "empty_n after drain", int'(empty_n), 0);
    endtask

    task automatic stream(input int nw, input int nr);
        fork
            begin
                for (int i = 0; i < nw; i++) begin
                    wr_cycle((i % 5) == 0, 1'b1, dat);
                    dat = dat + 18'h0137;
                end
                wr_cycle(1'b1, 1'b1, '0);
            end
            begin
                for (int j = 0; j < nr; j++) rd_cycle((j % 7) == 3);
                rd_cycle(1'b1);
            end
        join
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge wclk);
        #3 rst_n = 1'b1;
        @(negedge wclk);
        // R1: reset state
        chk(full_n && half_n && paf_n, "R1", "write flags high", int'({full_n, half_n, paf_n}), 7);
        chk(!empty_n && !pae_n, "R1", "read flags low", int'({empty_n, pae_n}), 0);
        chk(q == '0 && q_valid, "R1", "output zero and valid", int'(q), 0);

        // R4: the first word needs a read request
        wr_cycle(1'b0, 1'b1, 18'h2A5A5);
        wr_cycle(1'b1, 1'b1, '0);
        settle();
        chk(empty_n == 1'b1, "R6", "empty released after write", int'(empty_n), 1);
        chk(q == '0, "R4", "first word not shown before read", int'(q), 0);
        rd_cycle(1'b0);
        rd_cycle(1'b1);
        settle();
        chk(q == 18'h2A5A5, "R4", "first word after read", int'(q), int'(18'h2A5A5));

        // R3: reads while empty are ignored
        for (int i = 0; i < 3; i++) rd_cycle(1'b0);
        rd_cycle(1'b1);
        settle();
        chk(q == 18'h2A5A5, "R3", "read on empty ignored", int'(q), int'(18'h2A5A5));

        // Level flags with default offsets (R6, R7, R8)
        fill(31);  check_levels(DEF, DEF, "R8");
        fill(1);   check_levels(DEF, DEF, "R8");
        fill(96);  check_levels(DEF, DEF, "R8");
        fill(1);   check_levels(DEF, DEF, "R8");
        fill(95);  check_levels(DEF, DEF, "R8");
        fill(1);   check_levels(DEF, DEF, "R8");
        fill(31);  check_levels(DEF, DEF, "R8");
        chk(full_n == 1'b0, "R2", "full at DEPTH", int'(full_n), 0);
        fill(3);   check_levels(DEF, DEF, "R2");   // writes while full are ignored
        rd_cycle(1'b0);
        rd_cycle(1'b1);
        check_levels(DEF, DEF, "R8");
        chk(full_n == 1'b1, "R6", "full released after read", int'(full_n), 1);
        drain();

        // R9: offset loading, sequence kept across load sessions
        wr_cycle(1'b0, 1'b0, 18'd5);
        wr_cycle(1'b1, 1'b1, '0);
        wr_cycle(1'b0, 1'b0, 18'd10);
        wr_cycle(1'b1, 1'b1, '0);
        check_levels(5, 10, "R9");
        chk(exp_q.size() == 0 && !empty_n, "R9", "no word stored by load", int'(empty_n), 0);
        fill(5);   check_levels(5, 10, "R9");
        fill(1);   check_levels(5, 10, "R9");
        fill(239); check_levels(5, 10, "R9");
        fill(1);   check_levels(5, 10, "R9");
        drain();
        wr_cycle(1'b0, 1'b0, 18'd8);
        wr_cycle(1'b1, 1'b1, '0);
        fill(8);   check_levels(8, 10, "R9");
        fill(1);   check_levels(8, 10, "R9");
        drain();

        // R5: concurrent traffic on unrelated clocks
        stream(1500, 1400);
        drain();

        // R10: output enable
        fill(1);
        rd_cycle(1'b0);
        rd_cycle(1'b1);
        settle();
        wr_cycle(1'b1, 1'b1, '0);
        oe_n = 1'b1;
        @(negedge wclk);
        chk(q == '0 && !q_valid, "R10", "disabled output", int'(q), 0);
        wr_cycle(1'b1, 1'b1, '0);
        oe_n = 1'b0;
        @(negedge wclk);
        chk(q == last_q && q_valid, "R10", "enabled output", int'(q), int'(last_q));

        // R5: one shared clock
        same_clk = 1'b1;
        settle();
        stream(1200, 1100);
        drain();
        same_clk = 1'b0;
        settle();

        // R1: reset mid-run clears pointers and offsets
        fill(40);
        settle();
        @(posedge wclk); #3;
        rst_n = 1'b0;
        exp_q.delete();
        repeat (4) @(posedge wclk);
        #3 rst_n = 1'b1;
        @(negedge wclk);
        chk(q == '0, "R1", "output cleared by reset", int'(q), 0);
        check_levels(DEF, DEF, "R1");
        fill(32);  check_levels(DEF, DEF, "R1");
        drain();

        finish_run();
    end
endmodule